// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block decides which interrupt a small 8-bit CPU services next and gives the address of the two-byte vector for that interrupt. Seven sources share one fixed priority chain. From highest to lowest they are: the pending reset, the software interrupt, the external pin, timer capture, timer compare, timer overflow and the serial interface. Reset and the software interrupt are non-maskable. The other five are blocked while the block's mask flag is set.

The external pin has its own trigger stage. It can latch a falling edge, a rising edge or both edges, or it can pass a low level straight through. The latch is cleared at the moment the CPU accepts an external-pin interrupt. A further edge that arrives during the service routine is therefore held, and it is taken once the mask is cleared. Peripheral flags are level requests: the block never clears them.

The CPU side is a valid/ready pair. At each instruction boundary strobe, if the controller holds no offer, it arbitrates and may raise `take_valid` with a source code and a vector address. The offer (valid, source and vector) stays frozen until the CPU asserts `take_ack`, which acts as ready. A strobe that arrives while an offer is open is ignored. The handshake sets the mask flag. The CPU can also write the mask directly.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the mask flag reads 1, no offer is open, and the first boundary strobe offers source code 0 (reset) at vector 16'h1FFE. Accepting that offer retires the reset request.
- R2: Among the requests present at a boundary strobe, the lowest source code wins. The codes are: 0 reset, 1 software, 2 external pin, 3 capture, 4 compare, 5 overflow, 6 serial.
- R3: The vector address of the high byte is 16'h1FFE minus twice the source code. The low byte follows at that address plus one.
- R4: While the mask flag is 1, source codes 2 to 6 are never offered. Codes 0 and 1 are offered regardless of the mask.
- R5: ext_mode selects the pin trigger: 0 latches a falling edge, 1 a rising edge, 2 either edge, 3 requests while the pin is low, with nothing latched.
- R6: With ext_en at 0, pin activity neither latches nor requests.
- R7: The pin latch is cleared when an external-pin offer is accepted. An edge that occurs after that stays latched while the mask is 1, and it is offered at the first strobe after the mask is cleared.
- R8: An offer opens only in the cycle after a boundary strobe. While it waits for take_ack, its source and vector stay unchanged.
- R9: Accepting an offer (take_valid and take_ack both high) closes it and sets the mask flag to 1. This wins over a mask write in the same cycle.
- R10: Any set bit of cap_flags, of cmp_flags or of sci_flags raises that group's request. Peripheral requests stay pending for as long as their flags stay high.
- R11: A cycle with mask_wr high loads mask_wdata into the mask flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boundary | input | 1 | Instruction-boundary strobe; triggers arbitration |
| swi_req | input | 1 | Software interrupt request, held until accepted |
| ext_pin | input | 1 | External interrupt pin, synchronous to clk |
| ext_en | input | 1 | External interrupt enable |
| ext_mode | input | 2 | Pin trigger select (see R5) |
| cap_flags | input | CAP_N | Timer capture flags |
| cmp_flags | input | CMP_N | Timer compare flags |
| tov_flag | input | 1 | Timer overflow flag |
| sci_flags | input | SCI_N | Serial status flags: transmit empty, transmit done, overrun, receive full, line idle |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 1 | Value written to the mask |
| take_valid | output | 1 | Offer open |
| take_ack | input | 1 | CPU accepts the offer (ready) |
| take_src | output | 3 | Source code of the offer |
| take_vec | output | 16 | Vector high-byte address |
| mask_q | output | 1 | Current mask flag |

## Verification
The bench goes after the pin latch. A design that clears the latch on the wrong event would lose the pulse that arrives during service, or it would replay an interrupt that was already taken. A design that latches in level mode would keep requesting after the pin has risen. The bench also checks the priority chain under random flag mixes while the mask is set. A wrong mask gate would then show up as a timer or serial offer, or as a software interrupt that is lost. Strobes sent while an offer is open show whether a design re-arbitrates and lets the vector drift under the CPU.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int NUM_SRC = 7;
  localparam int SRC_W   = 3;

  localparam logic [SRC_W-1:0] SRC_RST = 3'd0;
  localparam logic [SRC_W-1:0] SRC_SWI = 3'd1;
  localparam logic [SRC_W-1:0] SRC_EXT = 3'd2;
  localparam logic [SRC_W-1:0] SRC_CAP = 3'd3;
  localparam logic [SRC_W-1:0] SRC_CMP = 3'd4;
  localparam logic [SRC_W-1:0] SRC_TOV = 3'd5;
  localparam logic [SRC_W-1:0] SRC_SCI = 3'd6;

  localparam logic [1:0] TRIG_FALL = 2'd0;
  localparam logic [1:0] TRIG_RISE = 2'd1;
  localparam logic [1:0] TRIG_BOTH = 2'd2;
  localparam logic [1:0] TRIG_LOW  = 2'd3;

  // Each lower-priority source sits one byte pair further down from the top vector.
  function automatic logic [15:0] vec_of(input logic [15:0] top, input logic [SRC_W-1:0] src);
    return top - {12'd0, src, 1'b0};
  endfunction
endpackage

// File: rtl/irqv_ext_latch.sv
module irqv_ext_latch
  import irqv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic       en,
  input  logic [1:0] mode,
  input  logic       clr,
  output logic       req
);
  logic pin_q, latch_q;
  logic fall, rise, set_ev;

  assign fall = pin_q & ~pin;
  assign rise = ~pin_q & pin;

  always_comb begin
    unique case (mode)
      TRIG_FALL: set_ev = fall;
      TRIG_RISE: set_ev = rise;
      TRIG_BOTH: set_ev = fall | rise;
      default:   set_ev = 1'b0;
    endcase
    set_ev = set_ev & en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q   <= 1'b1;
      latch_q <= 1'b0;
    end else begin
      pin_q <= pin;
      // A new edge outranks the clear that comes with acceptance.
      if (set_ev)   latch_q <= 1'b1;
      else if (clr) latch_q <= 1'b0;
    end
  end

  assign req = en & ((mode == TRIG_LOW) ? ~pin : latch_q);

  // R5: the latch only rises after the pin changed level
  a_r5_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_q) |-> ($past(pin) != $past(pin_q)));
  // R6: a disabled pin cannot set the latch
  a_r6_en_gates_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !latch_q) |=> !latch_q);
  // R7: a clear with no new edge empties the latch
  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_ev) |=> !latch_q);
endmodule

// File: rtl/irqv_arb.sv
module irqv_arb
  import irqv_pkg::*;
(
  input  logic [NUM_SRC-1:0] req,
  output logic               any,
  output logic [SRC_W-1:0]   win
);
  logic [NUM_SRC-1:0] grant;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chain
    if (i == 0) begin : g_top
      assign grant[i] = req[i];
    end else begin : g_rest
      assign grant[i] = req[i] & ~(|req[i-1:0]);
    end
  end

  assign any = |req;

  always_comb begin
    win = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (grant[i]) win = SRC_W'(i);
  end

  // R2: at most one source granted
  always_comb a_r2_one_grant: assert ($onehot0(grant));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int          CAP_N   = 2,
  parameter int          CMP_N   = 2,
  parameter int          SCI_N   = 5,
  parameter logic [15:0] VEC_TOP = 16'h1FFE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boundary,
  input  logic             swi_req,
  input  logic             ext_pin,
  input  logic             ext_en,
  input  logic [1:0]       ext_mode,
  input  logic [CAP_N-1:0] cap_flags,
  input  logic [CMP_N-1:0] cmp_flags,
  input  logic             tov_flag,
  input  logic [SCI_N-1:0] sci_flags,
  input  logic             mask_wr,
  input  logic             mask_wdata,
  output logic             take_valid,
  input  logic             take_ack,
  output logic [2:0]       take_src,
  output logic [15:0]      take_vec,
  output logic             mask_q
);
  logic               rst_pend_q;
  logic               accept;
  logic               ext_req;
  logic [NUM_SRC-1:0] req;
  logic               any;
  logic [SRC_W-1:0]   win;

  assign accept = take_valid & take_ack;

  irqv_ext_latch u_ext (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (ext_pin),
    .en    (ext_en),
    .mode  (ext_mode),
    .clr   (accept && take_src == SRC_EXT),
    .req   (ext_req)
  );

  always_comb begin
    req          = '0;
    req[SRC_RST] = rst_pend_q;
    req[SRC_SWI] = swi_req;
    req[SRC_EXT] = ext_req    & ~mask_q;
    req[SRC_CAP] = |cap_flags & ~mask_q;
    req[SRC_CMP] = |cmp_flags & ~mask_q;
    req[SRC_TOV] = tov_flag   & ~mask_q;
    req[SRC_SCI] = |sci_flags & ~mask_q;
  end

  irqv_arb u_arb (
    .req (req),
    .any (any),
    .win (win)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_valid <= 1'b0;
      take_src   <= SRC_RST;
      rst_pend_q <= 1'b1;
      mask_q     <= 1'b1;
    end else begin
      if (accept) begin
        take_valid <= 1'b0;
        if (take_src == SRC_RST) rst_pend_q <= 1'b0;
      end else if (!take_valid && boundary && any) begin
        take_valid <= 1'b1;
        take_src   <= win;
      end
      if (accept)       mask_q <= 1'b1;
      else if (mask_wr) mask_q <= mask_wdata;
    end
  end

  assign take_vec = vec_of(VEC_TOP, take_src);

  // R8: offers open only after a strobe
  a_r8_opens_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take_valid) |-> $past(boundary));
  // R8: an offer stays frozen until it is accepted
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && !take_ack) |=> (take_valid && $stable(take_src) && $stable(take_vec)));
  // R9: acceptance closes the offer and masks
  a_r9_accept_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && take_ack) |=> (mask_q && !take_valid));
  // R4: under the mask only non-maskable codes appear
  a_r4_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(take_valid) && $past(mask_q)) |-> (take_src == SRC_RST || take_src == SRC_SWI));
endmodule

// File: tb/irq_vector_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vector_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic boundary = 0, swi_req = 0, ext_pin = 1, ext_en = 0;
  logic [1:0] ext_mode = 0;
  logic [1:0] cap_flags = 0, cmp_flags = 0;
  logic tov_flag = 0;
  logic [4:0] sci_flags = 0;
  logic mask_wr = 0, mask_wdata = 0, take_ack = 0;
  logic take_valid, mask_q;
  logic [2:0] take_src;
  logic [15:0] take_vec;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (.*);

  function automatic logic [15:0] exp_vec(input int s);
    return 16'h1FFE - 16'(2 * s);
  endfunction

  // Returns the winning code, or 7 for no request.
  function automatic int exp_src(input logic sw, input logic m, input logic ex,
                                 input logic [1:0] c, input logic [1:0] k,
                                 input logic t, input logic [4:0] s);
    if (sw) return 1;
    if (m) return 7;
    if (ex) return 2;
    if (|c) return 3;
    if (|k) return 4;
    if (t) return 5;
    if (|s) return 6;
    return 7;
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk) boundary = 1;
    @(negedge clk) boundary = 0;
  endtask

  task automatic ack();
    @(negedge clk) take_ack = 1;
    @(negedge clk) take_ack = 0;
  endtask

  task automatic wr_mask(input logic v);
    @(negedge clk) begin mask_wr = 1; mask_wdata = v; end
    @(negedge clk) mask_wr = 0;
  endtask

  task automatic expect_offer(input string r, input int s);
    strobe();
    chk(r, take_valid, (s != 7));
    if (s != 7) begin
      chk(r, take_src, s);
      chk("R3", take_vec, exp_vec(s));
      ack();
      chk("R9", {take_valid, mask_q}, 2'b01);
    end
  endtask

  task automatic pin(input logic v);
    @(negedge clk) ext_pin = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", {take_valid, mask_q}, 2'b01);
    // R1 reset offered first, even with software pending
    swi_req = 1;
    strobe();
    chk("R1", take_src, 0);
    chk("R1", take_vec, 16'h1FFE);
    // R8 strobe while open does not re-arbitrate
    strobe();
    chk("R8", {take_valid, take_src}, {1'b1, 3'd0});
    ack();
    chk("R9", mask_q, 1);
    // R4 software taken under mask
    tov_flag = 1;
    expect_offer("R4", 1);
    swi_req = 0;
    expect_offer("R4", 7);
    // R11 and R10: unmask, overflow still pending
    wr_mask(0);
    chk("R11", mask_q, 0);
    expect_offer("R10", 5);
    wr_mask(0);
    expect_offer("R10", 5);
    tov_flag = 0;
    // R9 accept beats simultaneous mask write
    wr_mask(0);
    sci_flags = 5'b10000;
    strobe();
    @(negedge clk) begin take_ack = 1; mask_wr = 1; mask_wdata = 0; end
    @(negedge clk) begin take_ack = 0; mask_wr = 0; end
    chk("R9", mask_q, 1);
    sci_flags = 0;

    // R5 falling edge
    wr_mask(0);
    ext_en = 1; ext_mode = 2'd0;
    pin(0); pin(1);
    expect_offer("R5", 2);
    // R7 edge during service held under mask, served after unmask
    pin(0); pin(1);
    expect_offer("R7", 7);
    wr_mask(0);
    expect_offer("R7", 2);
    wr_mask(0);
    expect_offer("R7", 7);
    // R5 rising mode ignores a fall
    ext_mode = 2'd1;
    pin(0);
    expect_offer("R5", 7);
    pin(1);
    expect_offer("R5", 2);
    wr_mask(0);
    // R5 both edges
    ext_mode = 2'd2;
    pin(0);
    expect_offer("R5", 2);
    wr_mask(0);
    pin(1);
    expect_offer("R5", 2);
    wr_mask(0);
    // R5 level: request while low, none once high
    ext_mode = 2'd3;
    pin(0);
    expect_offer("R5", 2);
    wr_mask(0);
    pin(1);
    expect_offer("R5", 7);
    // R6 disabled pin
    ext_en = 0; ext_mode = 2'd0;
    pin(0); pin(1);
    expect_offer("R6", 7);
    ext_en = 1;
    expect_offer("R6", 7);
    ext_en = 0;

    // R2 random mixes
    for (int i = 0; i < 300; i++) begin
      logic m;
      m = 1'($urandom_range(0, 3) == 0);
      wr_mask(m);
      @(negedge clk) begin
        swi_req   = 1'($urandom_range(0, 5) == 0);
        cap_flags = 2'($urandom_range(0, 3)) & {2{1'($urandom_range(0, 1))}};
        cmp_flags = 2'($urandom_range(0, 3)) & {2{1'($urandom_range(0, 1))}};
        tov_flag  = 1'($urandom_range(0, 2) == 0);
        sci_flags = 5'($urandom) & {5{1'($urandom_range(0, 1))}};
      end
      expect_offer("R2", exp_src(swi_req, m, 1'b0, cap_flags, cmp_flags, tov_flag, sci_flags));
      swi_req = 0;
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule